// File: doc/BRIEF.md
# Converter Fault Supervisor with Retry Timer

This block supervises a switching regulator controller. It receives three synchronous fault flags: supply undervoltage, over-temperature and output short circuit. When any flag is seen, it drops into an idle state. In that state it holds the soft-start and compensation clamps on and withdraws the gate enable, which keeps the converter off. It then decides when a restart is allowed. The decision depends on which fault tripped it and on a long retry timer whose length is a parameter in clock ticks.

Each fault recovers in its own way. An undervoltage idle lasts exactly as long as its flag is asserted. A short circuit waits one retry period and then tries again, whatever the flag shows. An over-temperature wait keeps re-arming the timer until a period ends with the flag clear. Undervoltage overrides both timed waits. A timed wait that undervoltage interrupts is run again from the start once supply returns. Every restart releases the clamps and raises a one-cycle pulse, so the soft-start ramp begins again from zero. A two-bit status output reports the state. The comparators that produce the flags, the ramp and the drivers sit outside this block.

Top module: `conv_fault_supervisor`

## Requirements
- R1: In any idle state `ss_clamp` and `comp_clamp` are 1 and `gate_en` is 0. In the run state all three are inverted.
- R2: During reset and in the first cycle after it the status is undervoltage-idle. If no flag is set, the block enters run on the first edge after reset with a restart pulse.
- R3: An undervoltage flag seen on an edge puts the block in undervoltage-idle from that edge onward. The gate stays off for exactly as many cycles as the flag was sampled high.
- R4: A short-circuit wait lasts exactly RETRY_TICKS cycles and then returns to run regardless of the flag. A flag held high therefore yields one run cycle every RETRY_TICKS+1 cycles.
- R5: In a thermal wait, the timer re-arms at each expiry while the thermal flag is high. A thermal flag held for M sampled cycles gives an off time of RETRY_TICKS*ceil(M/RETRY_TICKS) cycles.
- R6: A thermal flag during a short-circuit wait switches to a thermal wait with a fresh period. A short-circuit flag during a thermal wait has no effect.
- R7: When undervoltage clears, the block starts a fresh timed wait if a wait was interrupted or if the thermal or short-circuit flag is high. Thermal takes precedence. Otherwise the block returns to run.
- R8: `restart_pulse` is high for exactly one cycle, namely the first run cycle after each idle period.
- R9: `fault_state` encodes run as 2'b00, undervoltage-idle as 2'b01, short-circuit wait as 2'b10 and thermal wait as 2'b11.
- R10: From run, simultaneous flags are resolved in the order undervoltage, then thermal, then short circuit. Any flag sampled in run turns the gate off on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_flag | input | 1 | Supply undervoltage fault, synchronous |
| therm_flag | input | 1 | Over-temperature fault, synchronous |
| short_flag | input | 1 | Output short-circuit fault, synchronous |
| ss_clamp | output | 1 | Holds the soft-start ramp at zero |
| comp_clamp | output | 1 | Pulls the compensation node low |
| gate_en | output | 1 | Permits the gate drivers to switch |
| restart_pulse | output | 1 | One-cycle pulse on each restart |
| fault_state | output | 2 | Encoded supervisor state |

## Verification
The properties assume that the three flags are already synchronous to `clk` and settle well before each edge. They make no assumption about overlaps: any flag may rise in any state, and any combination of flags may appear together. The stimulus drives every flag at the falling edge and holds it for whole cycles. It covers each fault alone and in combination, and it sweeps the hold lengths across several timer periods. This makes the off times computable as whole multiples of the retry period.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'b00,
      ST_UVLO = 2'b01,
      ST_SCW  = 2'b10,
      ST_OTW  = 2'b11
   } fsup_state_e;

   typedef enum logic [1:0] {
      PEND_NONE = 2'b00,
      PEND_SC   = 2'b01,
      PEND_OT   = 2'b10
   } fsup_pend_e;

   function automatic logic is_wait(input fsup_state_e s);
      return (s == ST_SCW) || (s == ST_OTW);
   endfunction

endpackage

// File: rtl/fsup_retry_timer.sv
module fsup_retry_timer #(
   parameter int unsigned TICKS      = 200,
   parameter bit          COUNT_DOWN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expire
);
   localparam int unsigned CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
   localparam logic [CW-1:0] ZERO = '0;

   logic [CW-1:0] cnt_q;

   generate
      if (COUNT_DOWN) begin : g_down
         assign expire = run && !load && (cnt_q == ZERO);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= LAST;
            else if (load)    cnt_q <= LAST;
            else if (run) begin
               if (cnt_q == ZERO) cnt_q <= LAST;
               else               cnt_q <= cnt_q - 1'b1;
            end
         end
      end else begin : g_up
         assign expire = run && !load && (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= ZERO;
            else if (load)    cnt_q <= ZERO;
            else if (run) begin
               if (cnt_q == LAST) cnt_q <= ZERO;
               else               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fsup_next_state.sv
module fsup_next_state
   import fsup_pkg::*;
(
   input  fsup_state_e state_q,
   input  fsup_pend_e  pend_q,
   input  logic        uv,
   input  logic        ot,
   input  logic        sc,
   input  logic        expire,
   output fsup_state_e state_d,
   output fsup_pend_e  pend_d,
   output logic        timer_load
);

   always_comb begin
      state_d = state_q;
      pend_d  = PEND_NONE;
      unique case (state_q)
         ST_RUN: begin
            if (uv)      state_d = ST_UVLO;
            else if (ot) state_d = ST_OTW;
            else if (sc) state_d = ST_SCW;
         end
         ST_UVLO: begin
            if (uv) begin
               pend_d = pend_q;
            end else if (ot || (pend_q == PEND_OT)) begin
               state_d = ST_OTW;
            end else if (sc || (pend_q == PEND_SC)) begin
               state_d = ST_SCW;
            end else begin
               state_d = ST_RUN;
            end
         end
         ST_SCW: begin
            if (uv) begin
               state_d = ST_UVLO;
               pend_d  = PEND_SC;
            end else if (ot) begin
               state_d = ST_OTW;
            end else if (expire) begin
               state_d = ST_RUN;
            end
         end
         ST_OTW: begin
            if (uv) begin
               state_d = ST_UVLO;
               pend_d  = PEND_OT;
            end else if (expire && !ot) begin
               state_d = ST_RUN;
            end
         end
         default: state_d = ST_UVLO;
      endcase
      timer_load = is_wait(state_d) && (state_d != state_q);
   end

endmodule

// File: rtl/fsup_drive.sv
module fsup_drive
   import fsup_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  fsup_state_e state_q,
   input  fsup_state_e state_d,
   output logic        ss_clamp,
   output logic        comp_clamp,
   output logic        gate_en,
   output logic        restart_pulse,
   output logic [1:0]  fault_state
);
   logic idle;
   logic pulse_q;

   assign idle        = (state_q != ST_RUN);
   assign ss_clamp    = idle;
   assign comp_clamp  = idle;
   assign gate_en     = ~idle;
   assign fault_state = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= (state_d == ST_RUN) && (state_q != ST_RUN);
   end

   assign restart_pulse = pulse_q;

endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor
   import fsup_pkg::*;
#(
   parameter int unsigned RETRY_TICKS = 20_000_000,
   parameter bit          COUNT_DOWN  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uvlo_flag,
   input  logic       therm_flag,
   input  logic       short_flag,
   output logic       ss_clamp,
   output logic       comp_clamp,
   output logic       gate_en,
   output logic       restart_pulse,
   output logic [1:0] fault_state
);

   generate
      if (RETRY_TICKS < 2) begin : g_bad_ticks
         $error("RETRY_TICKS must be at least 2");
      end
   endgenerate

   fsup_state_e state_q, state_d;
   fsup_pend_e  pend_q,  pend_d;
   logic        timer_load, timer_run, timer_expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_UVLO;
         pend_q  <= PEND_NONE;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   assign timer_run = is_wait(state_q);

   fsup_retry_timer #(
      .TICKS      (RETRY_TICKS),
      .COUNT_DOWN (COUNT_DOWN)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (timer_load),
      .run    (timer_run),
      .expire (timer_expire)
   );

   fsup_next_state nxt_i (
      .state_q    (state_q),
      .pend_q     (pend_q),
      .uv         (uvlo_flag),
      .ot         (therm_flag),
      .sc         (short_flag),
      .expire     (timer_expire),
      .state_d    (state_d),
      .pend_d     (pend_d),
      .timer_load (timer_load)
   );

   fsup_drive drv_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .state_q       (state_q),
      .state_d       (state_d),
      .ss_clamp      (ss_clamp),
      .comp_clamp    (comp_clamp),
      .gate_en       (gate_en),
      .restart_pulse (restart_pulse),
      .fault_state   (fault_state)
   );

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
   parameter int unsigned TICKS = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       uvlo_flag,
   input logic       therm_flag,
   input logic       short_flag,
   input logic       ss_clamp,
   input logic       comp_clamp,
   input logic       gate_en,
   input logic       restart_pulse,
   input logic [1:0] fault_state
);
   logic [31:0] sc_len;
   logic        prev_sc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_len  <= '0;
         prev_sc <= 1'b0;
      end else begin
         prev_sc <= (fault_state == 2'b10);
         if (fault_state == 2'b10) begin
            if (sc_len != 32'hFFFF_FFFF) sc_len <= sc_len + 1'b1;
         end else begin
            sc_len <= '0;
         end
      end
   end

   AST_IDLE_CLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_state != 2'b00) |-> (ss_clamp && comp_clamp && !gate_en)); // R1
   AST_UV_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_flag |=> (fault_state == 2'b01) && !gate_en); // R3
   AST_UV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_state == 2'b01) && !uvlo_flag) |=> (fault_state != 2'b01)); // R7
   AST_SC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_sc && (fault_state == 2'b00)) |-> (sc_len == TICKS)); // R4
   AST_OT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_state == 2'b11) && therm_flag && !uvlo_flag) |=> (fault_state == 2'b11)); // R5
   AST_OT_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_state == 2'b10) && therm_flag && !uvlo_flag) |=> (fault_state == 2'b11)); // R6
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse |=> !restart_pulse); // R8
   AST_PULSE_AT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse |-> (gate_en && $past(!gate_en))); // R8
   AST_RUN_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && (therm_flag || short_flag)) |=> !gate_en); // R10

endmodule

bind conv_fault_supervisor fsup_checker #(.TICKS(RETRY_TICKS)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .uvlo_flag     (uvlo_flag),
   .therm_flag    (therm_flag),
   .short_flag    (short_flag),
   .ss_clamp      (ss_clamp),
   .comp_clamp    (comp_clamp),
   .gate_en       (gate_en),
   .restart_pulse (restart_pulse),
   .fault_state   (fault_state)
);

// File: tb/conv_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module conv_fault_supervisor_tb_top;
   localparam int N = 5;
   localparam int T = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv_f = 1'b0, ot_f = 1'b0, sc_f = 1'b0;
   logic ss_clamp, comp_clamp, gate_en, restart_pulse;
   logic [1:0] fault_state;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   conv_fault_supervisor #(.RETRY_TICKS(N), .COUNT_DOWN(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .uvlo_flag(uv_f), .therm_flag(ot_f), .short_flag(sc_f),
      .ss_clamp(ss_clamp), .comp_clamp(comp_clamp), .gate_en(gate_en),
      .restart_pulse(restart_pulse), .fault_state(fault_state)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Called at a falling edge; flag windows are [start, start+len) in cycles.
   task automatic run_pat(input string req, input string name,
                          input int uvs, input int uvl, input int ots, input int otl,
                          input int scs, input int scl,
                          input int exp_off, input int exp_pulses,
                          input int probe_t, input int exp_st);
      int off = 0;
      int pul = 0;
      int st_seen = -1;
      int clamp_bad = 0;
      for (int t = 0; t < T; t++) begin
         uv_f = (t >= uvs) && (t < uvs + uvl);
         ot_f = (t >= ots) && (t < ots + otl);
         sc_f = (t >= scs) && (t < scs + scl);
         @(posedge clk);
         @(negedge clk);
         if (!gate_en) off++;
         if (restart_pulse) pul++;
         if (t == probe_t) st_seen = int'(fault_state);
         if ((ss_clamp !== ~gate_en) || (comp_clamp !== ~gate_en)) clamp_bad++;
      end
      uv_f = 1'b0; ot_f = 1'b0; sc_f = 1'b0;
      check(req, {name, " off cycles"}, off, exp_off);
      check("R8", {name, " restart pulses"}, pul, exp_pulses);
      check("R9", {name, " status at probe"}, st_seen, exp_st);
      check("R1", {name, " clamp/gate mismatches"}, clamp_bad, 0);
      check("R1", {name, " running at end"}, int'(gate_en), 1);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state
      check("R2", "reset status", int'(fault_state), 1);
      check("R2", "reset ss_clamp", int'(ss_clamp), 1);
      check("R2", "reset comp_clamp", int'(comp_clamp), 1);
      check("R2", "reset gate_en", int'(gate_en), 0);
      check("R2", "reset pulse", int'(restart_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", "first run gate_en", int'(gate_en), 1);
      check("R2", "first restart pulse", int'(restart_pulse), 1);
      @(negedge clk);
      check("R8", "pulse drops", int'(restart_pulse), 0);
      check("R9", "run status", int'(fault_state), 0);

      // R3 undervoltage sweep
      for (int l = 1; l <= 6; l++)
         run_pat("R3", $sformatf("uv len %0d", l), 0, l, 0, 0, 0, 0, l, 1, 0, 1);

      // R4 single short circuit, and held short circuit (hiccup)
      run_pat("R4", "sc single", 0, 0, 0, 0, 0, 1, N, 1, 1, 2);
      run_pat("R4", "sc hiccup", 0, 0, 0, 0, 0, 2 * (N + 1), 2 * N, 2, N, 0);

      // R5 thermal sweep: off time is N*ceil(M/N)
      for (int m = 1; m <= 12; m++)
         run_pat("R5", $sformatf("ot len %0d", m), 0, 0, 0, m, 0, 0,
                 N * ((m + N - 1) / N), 1, 0, 3);

      // R6 thermal preempts short wait; short ignored in thermal wait
      run_pat("R6", "ot in sc wait", 0, 0, 2, 1, 0, 1, 2 + N, 1, 2, 3);
      run_pat("R6", "sc in ot wait", 0, 0, 0, 1, 2, 2, N, 1, 3, 3);

      // R7 undervoltage interrupts timed waits
      run_pat("R7", "uv in sc wait a", 2, 3, 0, 0, 0, 1, 5 + N, 1, 3, 1);
      run_pat("R7", "uv in sc wait b", 2, 3, 0, 0, 0, 1, 5 + N, 1, 5, 2);
      run_pat("R7", "uv in ot wait", 2, 3, 0, 1, 0, 0, 5 + N, 1, 5, 3);
      run_pat("R7", "uv then live ot", 0, 3, 0, 5, 0, 0, 3 + N, 1, 3, 3);

      // R10 priority from run
      run_pat("R10", "uv+ot together", 0, 3, 0, 5, 0, 0, 3 + N, 1, 0, 1);
      run_pat("R10", "ot+sc together", 0, 0, 0, 1, 0, 1, N, 1, 0, 3);
      run_pat("R10", "all three", 0, 1, 0, 1, 0, 1, 1, 1, 0, 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule